// File: doc/BRIEF.md
# Streaming Vector Realigner

This block takes a stream of vectors that were fetched only from aligned addresses. It produces a stream in which each element has moved from a source byte offset to a target byte offset. Each output vector is cut from a pair of neighbouring input vectors. A run of consecutive bytes that crosses an aligned boundary therefore arrives in a single output word. The block keeps the earlier vector of each pair in a held register and only takes in the later one. As a result, every aligned word enters the block exactly once.

A stream opens with a priming beat, marked by the start qualifier. The priming beat loads the held register and fixes the shift amount from the two offsets presented with it. It produces no output. For a left shift (source offset above target) the priming word is the first word of the stream. For a right shift (source offset below target) it is the aligned word just before the first one. Each data beat that follows produces exactly one output vector. The output is cut from the held vector followed by the incoming one, and the incoming vector then becomes the held one. Both sides use valid/ready handshakes, and the offsets may change at run time between streams.

Top module: `realigner`

## Requirements
- R1: After reset, out_valid and in_ready are 0, out_data is all zeros, and no data beat is accepted until a priming beat has been taken.
- R2: A beat presented with in_start high is accepted whatever the output state (in_ready is 1). It produces no output, and it leaves any output word still waiting untouched.
- R3: The shift amount is l = (src_off − dst_off) mod 16. It is taken from the offsets presented with the priming beat. Offset changes during data beats have no effect on the outputs.
- R4: Byte i of a vector is bits [8i+7:8i]. For l ≠ 0, output byte k is byte l+k of the 32-byte join, where join bytes 0..15 are the held vector and bytes 16..31 are the incoming vector. With source offset 3 and target 0, output j holds stream bytes 16j+3 to 16j+18.
- R5: With source offset 0 and target 5 (l = 11), priming with the preceding word gives output j holding stream bytes 16j+11 to 16j+26. The first byte of word j+1 lands at output byte 5.
- R6: When l = 0, the output equals the incoming data beat unchanged.
- R7: Each accepted data beat (in_start low) produces exactly one output vector on the next cycle. That beat then becomes the held vector.
- R8: A data beat is accepted only when a stream has been primed and the output register is empty or being drained in the same cycle. Before the first priming beat, data beats are not accepted.
- R9: While out_valid is 1 and out_ready is 0, out_valid and out_data stay unchanged.
- R10: A priming beat in the middle of a stream restarts it with the new offsets and the new held vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat taken this cycle when in_valid is high |
| in_start | input | 1 | Marks the beat as a priming beat |
| in_data | input | 128 | Aligned input vector, byte i at bits [8i+7:8i] |
| src_off | input | 4 | Stream offset of the source, sampled on a priming beat |
| dst_off | input | 4 | Desired offset of the output, sampled on a priming beat |
| out_valid | output | 1 | Output vector present |
| out_ready | input | 1 | Consumer takes the output vector |
| out_data | output | 128 | Realigned vector |

## Verification
The bench builds the block with its defaults: 16 one-byte lanes and a 4-bit offset. This makes every shift amount, including the zero case and the largest value of 15, reachable with small streams. Byte values follow their stream address, so each realigned output can be checked against an address formula for left, right and zero shifts. A behavioural model also compares handshake and data on every clock, under consumer stalls up to a permanently blocked output, input gaps, offset changes during data beats and re-priming.

// File: rtl/realign_pkg.sv
package realign_pkg;

    localparam int unsigned VEC_BYTES_DFLT = 16;
    localparam int unsigned LANE_BITS_DFLT = 8;

    // Difference of two offsets wrapped into 0..m-1 (m a power of two).
    function automatic int unsigned wrap_sub(input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned m);
        return (a + m - b) % m;
    endfunction

endpackage

// File: rtl/realign_cfg.sv
module realign_cfg #(
    parameter int unsigned VBYTES = realign_pkg::VEC_BYTES_DFLT,
    localparam int unsigned OFF_W = $clog2(VBYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [OFF_W-1:0] src_off,
    input  logic [OFF_W-1:0] dst_off,
    output logic [OFF_W-1:0] shift_amt
);
    import realign_pkg::*;

    logic [OFF_W-1:0] shift_next;

    always_comb begin
        shift_next = OFF_W'(wrap_sub(int'(src_off), int'(dst_off), VBYTES));
    end

    // Offsets are captured only with the priming beat.
    always_ff @(posedge clk) begin
        if (rst) begin
            shift_amt <= '0;
        end else if (load) begin
            shift_amt <= shift_next;
        end
    end
endmodule

// File: rtl/realign_shiftpair.sv
module realign_shiftpair #(
    parameter int unsigned VBYTES = realign_pkg::VEC_BYTES_DFLT,
    parameter int unsigned BYTE_W = realign_pkg::LANE_BITS_DFLT,
    localparam int unsigned OFF_W = $clog2(VBYTES),
    localparam int unsigned IDX_W = OFF_W + 1,
    localparam int unsigned DW    = VBYTES * BYTE_W
) (
    input  logic [DW-1:0]    first_vec,
    input  logic [DW-1:0]    second_vec,
    input  logic [OFF_W-1:0] shift,
    output logic [DW-1:0]    result
);
    logic [BYTE_W-1:0] joined [2*VBYTES];
    logic [DW-1:0]     picked;

    // Double-length value: earlier vector in the low half.
    for (genvar i = 0; i < VBYTES; i++) begin : g_join
        assign joined[i]          = first_vec[i*BYTE_W +: BYTE_W];
        assign joined[i + VBYTES] = second_vec[i*BYTE_W +: BYTE_W];
    end

    // Permute control: each lane selects joined byte shift + lane.
    for (genvar k = 0; k < VBYTES; k++) begin : g_lane
        logic [IDX_W-1:0] sel;
        assign sel = {1'b0, shift} + IDX_W'(k);
        assign picked[k*BYTE_W +: BYTE_W] = joined[sel];
    end

    // Zero shift passes the incoming word straight through.
    assign result = (shift == '0) ? second_vec : picked;
endmodule

// File: rtl/realign_stage.sv
module realign_stage #(
    parameter int unsigned DW = realign_pkg::VEC_BYTES_DFLT * realign_pkg::LANE_BITS_DFLT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prime_fire,
    input  logic          data_fire,
    input  logic [DW-1:0] in_data,
    input  logic [DW-1:0] pair_result,
    input  logic          out_ready,
    output logic [DW-1:0] held_vec,
    output logic          primed,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_vec <= '0;
            primed   <= 1'b0;
        end else if (prime_fire) begin
            held_vec <= in_data;
            primed   <= 1'b1;
        end else if (data_fire) begin
            held_vec <= in_data;   // new becomes old for the next pair
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (data_fire) begin
            out_valid <= 1'b1;
            out_data  <= pair_result;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/realigner.sv
module realigner #(
    parameter int unsigned VBYTES = realign_pkg::VEC_BYTES_DFLT,
    parameter int unsigned BYTE_W = realign_pkg::LANE_BITS_DFLT
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    output logic                            in_ready,
    input  logic                            in_start,
    input  logic [VBYTES*BYTE_W-1:0]        in_data,
    input  logic [$clog2(VBYTES)-1:0]       src_off,
    input  logic [$clog2(VBYTES)-1:0]       dst_off,
    output logic                            out_valid,
    input  logic                            out_ready,
    output logic [VBYTES*BYTE_W-1:0]        out_data
);
    localparam int unsigned OFF_W = $clog2(VBYTES);
    localparam int unsigned DW    = VBYTES * BYTE_W;

    logic [OFF_W-1:0] shift_amt;
    logic [DW-1:0]    held_vec;
    logic [DW-1:0]    pair_result;
    logic             primed;
    logic             prime_fire;
    logic             data_fire;
    logic             out_space;

    assign out_space  = !out_valid || out_ready;
    assign in_ready   = in_start || (primed && out_space);
    assign prime_fire = in_valid && in_start;
    assign data_fire  = in_valid && !in_start && primed && out_space;

    realign_cfg #(.VBYTES(VBYTES)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .load      (prime_fire),
        .src_off   (src_off),
        .dst_off   (dst_off),
        .shift_amt (shift_amt)
    );

    realign_shiftpair #(.VBYTES(VBYTES), .BYTE_W(BYTE_W)) u_pair (
        .first_vec  (held_vec),
        .second_vec (in_data),
        .shift      (shift_amt),
        .result     (pair_result)
    );

    realign_stage #(.DW(DW)) u_stage (
        .clk         (clk),
        .rst         (rst),
        .prime_fire  (prime_fire),
        .data_fire   (data_fire),
        .in_data     (in_data),
        .pair_result (pair_result),
        .out_ready   (out_ready),
        .held_vec    (held_vec),
        .primed      (primed),
        .out_valid   (out_valid),
        .out_data    (out_data)
    );
endmodule

// File: rtl/realign_chk.sv
module realign_chk #(
    parameter int unsigned DW    = 128,
    parameter int unsigned OFF_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_start,
    input logic [DW-1:0]    in_data,
    input logic             out_valid,
    input logic             out_ready,
    input logic [DW-1:0]    out_data,
    input logic [OFF_W-1:0] shift_amt
);
    AST_PRIME_SILENT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_start && (!out_valid || out_ready)) |=> !out_valid); // R2

    AST_SHIFT_HELD: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_start) |=> $stable(shift_amt)); // R3

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !in_start && shift_amt == '0)
        |=> (out_valid && out_data == $past(in_data))); // R6

    AST_ONE_OUT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !in_start) |=> out_valid); // R7

    AST_NO_TAKE_STALLED: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !in_start) |-> !in_ready); // R8

    AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
endmodule

bind realigner realign_chk #(.DW(VBYTES*BYTE_W), .OFF_W($clog2(VBYTES))) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_start  (in_start),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .shift_amt (shift_amt)
);

// File: tb/sim_realigner.sv
`timescale 1ns/1ps
module sim_realigner;
    localparam int V  = 16;
    localparam int DW = V * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          in_start = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [3:0]    src_off = '0;
    logic [3:0]    dst_off = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [DW-1:0] out_data;

    realigner u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_start(in_start), .in_data(in_data), .src_off(src_off),
        .dst_off(dst_off), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    always #2 clk = ~clk;

    int            n_chk = 0;
    int            n_fail = 0;
    string         tag = "R1";
    int            stall_pct = 0;
    logic [DW-1:0] got [$];

    // Behavioural reference state
    logic          m_primed = 1'b0;
    logic          m_ov = 1'b0;
    logic [DW-1:0] m_old = '0;
    logic [DW-1:0] m_od = '0;
    int            m_sh = 0;

    task automatic chk(input bit ok, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] addr_vec(input int first);
        logic [DW-1:0] v;
        for (int k = 0; k < V; k++) v[k*8 +: 8] = 8'((first + k) & 255);
        return v;
    endfunction

    function automatic logic [DW-1:0] mk_vec(input int n, input int base);
        return addr_vec(16 * n + base);
    endfunction

    function automatic logic [DW-1:0] ref_pair(input logic [DW-1:0] older,
                                               input logic [DW-1:0] newer,
                                               input int sh);
        logic [DW-1:0] r;
        for (int k = 0; k < V; k++) begin
            int p = sh + k;
            if (sh == 0)     r[k*8 +: 8] = newer[k*8 +: 8];
            else if (p < V)  r[k*8 +: 8] = older[p*8 +: 8];
            else             r[k*8 +: 8] = newer[(p-V)*8 +: 8];
        end
        return r;
    endfunction

    function automatic bit m_rdy();
        return in_start ? 1'b1 : (m_primed && (!m_ov || out_ready));
    endfunction

    always @(posedge clk) begin
        bit r;
        if (rst) begin
            m_primed = 1'b0; m_ov = 1'b0; m_old = '0; m_od = '0; m_sh = 0;
        end else begin
            r = m_rdy();
            if (m_ov && out_ready) m_ov = 1'b0;
            if (in_valid && r) begin
                if (in_start) begin
                    m_old = in_data;
                    m_primed = 1'b1;
                    m_sh = (int'(src_off) - int'(dst_off) + V) % V;
                end else begin
                    m_od = ref_pair(m_old, in_data, m_sh);
                    m_ov = 1'b1;
                    m_old = in_data;
                end
            end
        end
    end

    always @(negedge clk) out_ready <= (($urandom % 100) >= stall_pct);

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            chk(in_ready == m_rdy(), "in_ready", DW'(in_ready), DW'(m_rdy()));
            chk(out_valid == m_ov, "out_valid", DW'(out_valid), DW'(m_ov));
            if (m_ov) chk(out_data == m_od, "out_data", out_data, m_od);
            if (out_valid && out_ready) got.push_back(out_data);
        end
    end

    task automatic send(input logic [DW-1:0] v, input bit st);
        @(negedge clk);
        in_valid = 1'b1; in_data = v; in_start = st;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic run(input int src, input int dst, input int n, input int base,
                       input int stall, input bit gaps, input bit scramble);
        got.delete();
        stall_pct = stall;
        src_off = 4'(src); dst_off = 4'(dst);
        send(mk_vec(0, base), 1'b1);
        for (int j = 1; j <= n; j++) begin
            if (scramble) begin
                src_off = 4'($urandom); dst_off = 4'($urandom);
            end
            if (gaps && ($urandom % 3 == 0)) idle();
            send(mk_vec(j, base), 1'b0);
        end
        idle();
        stall_pct = 0;
        for (int w = 0; w < 50; w++) idle();
        chk(got.size() == n, "output count", DW'(got.size()), DW'(n)); // R7
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        tag = "R1";
        chk(out_valid == 1'b0, "reset out_valid", DW'(out_valid), '0);
        chk(in_ready == 1'b0, "reset in_ready", DW'(in_ready), '0);
        chk(out_data == '0, "reset out_data", out_data, '0);

        // R8: data beats before any priming are refused
        tag = "R8";
        @(negedge clk); in_valid = 1'b1; in_data = mk_vec(3, 7); in_start = 1'b0;
        repeat (6) @(negedge clk);
        #1;
        chk(in_ready == 1'b0, "unprimed in_ready", DW'(in_ready), '0);
        chk(out_valid == 1'b0, "unprimed out_valid", DW'(out_valid), '0);
        @(posedge clk); #1;
        idle();

        // R4: left shift, source offset 3 to target 0
        tag = "R4";
        run(3, 0, 8, 0, 0, 1'b0, 1'b0);
        for (int j = 0; j < 8 && j < got.size(); j++)
            chk(got[j] == addr_vec(16*j + 3), "left shift word", got[j], addr_vec(16*j + 3));

        // R5: right shift, source offset 0 to target 5
        tag = "R5";
        run(0, 5, 8, 64, 30, 1'b1, 1'b0);
        for (int j = 0; j < 8 && j < got.size(); j++)
            chk(got[j] == addr_vec(16*j + 11 + 64), "right shift word", got[j], addr_vec(16*j + 75));

        // R6: equal offsets pass each beat through
        tag = "R6";
        run(7, 7, 6, 5, 20, 1'b0, 1'b0);
        for (int j = 0; j < 6 && j < got.size(); j++)
            chk(got[j] == mk_vec(j + 1, 5), "zero shift word", got[j], mk_vec(j + 1, 5));

        // R3: offsets changed during data beats are ignored (l = 7)
        tag = "R3";
        run(9, 2, 12, 17, 40, 1'b1, 1'b1);
        for (int j = 0; j < 12 && j < got.size(); j++)
            chk(got[j] == addr_vec(16*j + 7 + 17), "latched shift word", got[j], addr_vec(16*j + 24));

        // R9: heavy stalls with the largest shift
        tag = "R9";
        run(15, 0, 20, 200, 70, 1'b1, 1'b0);

        // R10: re-prime with new offsets straight after another stream
        tag = "R10";
        run(1, 14, 10, 33, 25, 1'b1, 1'b0);
        for (int j = 0; j < 10 && j < got.size(); j++)
            chk(got[j] == addr_vec(16*j + 3 + 33), "re-primed word", got[j], addr_vec(16*j + 36));

        // R2: priming beat taken while the output is blocked, output untouched
        tag = "R2";
        stall_pct = 100;
        src_off = 4'd0; dst_off = 4'd0;
        send(mk_vec(0, 90), 1'b1);
        send(mk_vec(1, 90), 1'b0);
        @(negedge clk); in_valid = 1'b0; in_start = 1'b0;
        #1;
        begin
            logic [DW-1:0] held;
            held = out_data;
            src_off = 4'd4; dst_off = 4'd1;
            send(mk_vec(9, 11), 1'b1);
            @(negedge clk); in_valid = 1'b0; in_start = 1'b0;
            #1;
            chk(out_valid == 1'b1, "stalled valid after prime", DW'(out_valid), DW'(1));
            chk(out_data == held, "stalled data after prime", out_data, held);
        end
        stall_pct = 0;
        for (int w = 0; w < 10; w++) idle();

        summary();
        $finish;
    end
endmodule